// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an addressing request into a memory address, using one of two selectable schemes. In the 16-bit scheme, a segment value is moved up by one paragraph of 16 bytes and added to a 16-bit offset. The result is a 20-bit physical address. Each segment therefore covers 64 KB and starts on a paragraph boundary.

In the 32-bit scheme, the block first forms an effective address. It adds a base, an index scaled by 1, 2, 4 or 8, and a displacement. The displacement is 8, 16 or 32 bits wide, and narrow displacements are sign-extended. A 32-bit segment base, supplied directly by the caller, is then added to give the linear address.

A request is presented with a one-cycle valid strobe. The address comes out of a register one clock later, together with its own valid flag. Every sum wraps silently at the width of its scheme. No fault is ever raised. Descriptor lookup and page translation belong to other blocks.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted, and until the first accepted request, `out_valid` is 0 and `addr_out` is 0.
- R2: With `mode` = 0 (16-bit scheme), `addr_out` = ((`seg_in[15:0]` × 16) + `base_in[15:0]`) mod 2^20, and `addr_out[31:20]` is 0.
- R3: In the 16-bit scheme, `index_in`, `disp_in`, `scale_code`, `disp_size`, `seg_in[31:16]` and `base_in[31:16]` have no effect on `addr_out`.
- R4: With `mode` = 1 (32-bit scheme), `addr_out` = (`seg_in` + `base_in` + scaled index + extended displacement) mod 2^32.
- R5: `scale_code` selects the index multiplier as a left shift of 0, 1, 2 or 3 bits, so values 0..3 give ×1, ×2, ×4 and ×8.
- R6: `disp_size` selects the displacement, which is then added. The codes are: 0 = `disp_in[7:0]` sign-extended to 32 bits, 1 = `disp_in[15:0]` sign-extended, 2 = all 32 bits of `disp_in`, and 3 = no displacement (zero).
- R7: Carries out of the top bit are dropped in both schemes (20 bits and 32 bits). No other output reacts to a wrap.
- R8: `out_valid` equals `in_valid` delayed by exactly one clock. `addr_out` is updated at the same edge that raises `out_valid`.
- R9: While `in_valid` is 0, `addr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| mode | input | 1 | 0 = 16-bit paragraph scheme, 1 = 32-bit scaled-index scheme |
| seg_in | input | 32 | Segment value (low 16 bits) or segment base (all 32) |
| base_in | input | 32 | Base; low 16 bits are the offset in the 16-bit scheme |
| index_in | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount 0..3 |
| disp_in | input | 32 | Displacement field |
| disp_size | input | 2 | Displacement width code |
| out_valid | output | 1 | Address valid, one clock after `in_valid` |
| addr_out | output | 32 | Registered address |

## Verification
The bench builds the block with its default widths: a 32-bit address, a 16-bit segment value and a 4-bit paragraph shift. These widths make the 20-bit wrap of the paragraph scheme and the 32-bit wrap of the scaled scheme both reachable with simple edge operands, such as all-ones segments and offsets. Because the 16-bit and 32-bit schemes share input pins, the bench can load junk on the unused fields and show that they are ignored. Negative 8-bit and 16-bit displacements expose the sign extension.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic {
    AMODE_PARA = 1'b0,
    AMODE_SCALED = 1'b1
  } amode_e;

  typedef enum logic [1:0] {
    DSZ_BYTE = 2'd0,
    DSZ_HALF = 2'd1,
    DSZ_FULL = 2'd2,
    DSZ_NONE = 2'd3
  } dsz_e;

endpackage

// File: rtl/sag_disp_ext.sv
module sag_disp_ext #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] disp_raw,
  input  logic [1:0]    size_code,
  output logic [AW-1:0] disp_wide
);
  import seg_addr_pkg::*;

  localparam int B_W = 8;
  localparam int H_W = 16;

  dsz_e sz;
  assign sz = dsz_e'(size_code);

  always_comb begin
    unique case (sz)
      DSZ_BYTE: disp_wide = {{(AW-B_W){disp_raw[B_W-1]}}, disp_raw[B_W-1:0]};
      DSZ_HALF: disp_wide = {{(AW-H_W){disp_raw[H_W-1]}}, disp_raw[H_W-1:0]};
      DSZ_FULL: disp_wide = disp_raw;
      default:  disp_wide = '0;
    endcase
  end

  // R6: a narrow displacement must keep its own low bits, and its upper bits must copy its sign
  always_comb begin
    if (!$isunknown({size_code, disp_raw})) begin
      if (sz == DSZ_BYTE)
        assert_sext_byte_R6: assert ((disp_wide[B_W-1:0] == disp_raw[B_W-1:0]) &&
                                     ($signed(disp_wide) < 0) == disp_raw[B_W-1]);
      if (sz == DSZ_HALF)
        assert_sext_half_R6: assert ((disp_wide[H_W-1:0] == disp_raw[H_W-1:0]) &&
                                     ($signed(disp_wide) < 0) == disp_raw[H_W-1]);
    end
  end

endmodule

// File: rtl/sag_para_path.sv
module sag_para_path #(
  parameter int SEG_W = 16,
  parameter int PSH   = 4,
  parameter int AW    = 32
) (
  input  logic [SEG_W-1:0] seg_val,
  input  logic [SEG_W-1:0] ofs_val,
  output logic [AW-1:0]    phys
);
  localparam int PW = SEG_W + PSH;

  logic [PW-1:0] seg_sh;
  logic [PW-1:0] ofs_ext;
  logic [PW-1:0] sum_p;

  assign seg_sh  = {seg_val, {PSH{1'b0}}};
  assign ofs_ext = {{PSH{1'b0}}, ofs_val};
  assign sum_p   = seg_sh + ofs_ext;
  assign phys    = {{(AW-PW){1'b0}}, sum_p};

  // R2: a segment starts on a paragraph, so the offset alone fixes the low bits
  always_comb begin
    if (!$isunknown({seg_val, ofs_val}))
      assert_paragraph_low_R2: assert (phys[PSH-1:0] == ofs_val[PSH-1:0]);
  end

endmodule

// File: rtl/sag_scaled_path.sv
module sag_scaled_path #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [1:0]    scale_code,
  input  logic [AW-1:0] disp_wide,
  output logic [AW-1:0] lin
);
  logic [AW-1:0] idx_scaled;
  logic [AW-1:0] eff;

  assign idx_scaled = index_val << scale_code;
  assign eff        = base_val + idx_scaled + disp_wide;
  assign lin        = seg_base + eff;

  // R5: scaling only shifts in zeros at the bottom
  always_comb begin
    if (!$isunknown({index_val, scale_code}))
      assert_scale_zero_low_R5: assert (scale_code == 2'd0 ? idx_scaled == index_val
                                        : idx_scaled[0] == 1'b0);
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int AW    = 32,
  parameter int SEG_W = 16,
  parameter int PSH   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          mode,
  input  logic [AW-1:0] seg_in,
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] index_in,
  input  logic [1:0]    scale_code,
  input  logic [AW-1:0] disp_in,
  input  logic [1:0]    disp_size,
  output logic          out_valid,
  output logic [AW-1:0] addr_out
);
  import seg_addr_pkg::*;

  localparam int PW = SEG_W + PSH;

  // reset synchronizer: asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [AW-1:0] disp_wide;
  logic [AW-1:0] para_addr;
  logic [AW-1:0] scaled_addr;

  sag_disp_ext #(.AW(AW)) i_disp (
    .disp_raw  (disp_in),
    .size_code (disp_size),
    .disp_wide (disp_wide)
  );

  sag_para_path #(.SEG_W(SEG_W), .PSH(PSH), .AW(AW)) i_para (
    .seg_val (seg_in[SEG_W-1:0]),
    .ofs_val (base_in[SEG_W-1:0]),
    .phys    (para_addr)
  );

  sag_scaled_path #(.AW(AW)) i_scaled (
    .seg_base   (seg_in),
    .base_val   (base_in),
    .index_val  (index_in),
    .scale_code (scale_code),
    .disp_wide  (disp_wide),
    .lin        (scaled_addr)
  );

  // next state
  logic          vld_d, vld_q;
  logic [AW-1:0] addr_d, addr_q;
  logic          addr_en;

  assign addr_en = in_valid;

  always_comb begin
    vld_d  = in_valid;
    addr_d = addr_q;
    if (addr_en)
      addr_d = (amode_e'(mode) == AMODE_PARA) ? para_addr : scaled_addr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
    end
  end

  assign out_valid = vld_q;
  assign addr_out  = addr_q;

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);
  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(addr_out));
  assert_para_width_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && mode == 1'b0) |=> (addr_out[AW-1:PW] == '0));

endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        mode;
  logic [31:0] seg_in, base_in, index_in, disp_in;
  logic [1:0]  scale_code, disp_size;
  logic        out_valid;
  logic [31:0] addr_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .seg_in(seg_in), .base_in(base_in), .index_in(index_in),
    .scale_code(scale_code), .disp_in(disp_in), .disp_size(disp_size),
    .out_valid(out_valid), .addr_out(addr_out)
  );

  function automatic logic [31:0] model(input logic m, input logic [31:0] s,
      input logic [31:0] b, input logic [31:0] ix, input logic [1:0] sc,
      input logic [31:0] d, input logic [1:0] dz);
    logic [31:0] dw;
    logic [19:0] p;
    if (!m) begin
      p = {s[15:0], 4'h0} + {4'h0, b[15:0]};
      return {12'h000, p};
    end
    case (dz)
      2'd0: dw = {{24{d[7]}}, d[7:0]};
      2'd1: dw = {{16{d[15]}}, d[15:0]};
      2'd2: dw = d;
      default: dw = 32'h0;
    endcase
    return s + b + (ix << sc) + dw;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request, checked one clock later
  task automatic request(input string req, input logic m, input logic [31:0] s,
      input logic [31:0] b, input logic [31:0] ix, input logic [1:0] sc,
      input logic [31:0] d, input logic [1:0] dz);
    @(negedge clk);
    in_valid = 1'b1; mode = m; seg_in = s; base_in = b; index_in = ix;
    scale_code = sc; disp_in = d; disp_size = dz;
    @(posedge clk); #1;
    check({req, " valid"}, {31'h0, out_valid}, 32'h1);
    check(req, addr_out, model(m, s, b, ix, sc, d, dz));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    check("R1 valid in reset", {31'h0, out_valid}, 32'h0);
    check("R1 addr in reset", addr_out, 32'h0);
  endtask

  task automatic t_para;
    request("R2 basic", 1'b0, 32'h0000_1234, 32'h0000_0010, 0, 0, 0, 0);
    check("R2 value", addr_out, 32'h0001_2350);
    request("R7 para wrap", 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 0, 0);
    check("R7 value", addr_out, 32'h0000_FFEF);
    request("R3 junk fields", 1'b0, 32'hABCD_0100, 32'h5555_0002, 32'hFFFF_FFFF,
            2'd3, 32'h8000_0080, 2'd0);
    check("R3 value", addr_out, 32'h0000_1002);
  endtask

  task automatic t_scale;
    for (int k = 0; k < 4; k++) begin
      request("R5 scale", 1'b1, 32'h0001_0000, 32'h100, 32'h10, k[1:0], 0, 2'd3);
      check("R5 value", addr_out, 32'h0001_0100 + (32'h10 << k));
    end
  endtask

  task automatic t_disp;
    request("R6 byte neg", 1'b1, 32'h1000, 32'h200, 32'h0, 2'd0, 32'h1234_56FE, 2'd0);
    check("R6 byte value", addr_out, 32'h0000_11FE);
    request("R6 half neg", 1'b1, 32'h1000, 32'h0, 32'h0, 2'd0, 32'hAAAA_FF00, 2'd1);
    check("R6 half value", addr_out, 32'h0000_0F00);
    request("R6 full", 1'b1, 32'h0, 32'h0, 32'h0, 2'd0, 32'h8000_0004, 2'd2);
    request("R6 none", 1'b1, 32'h40, 32'h0, 32'h0, 2'd0, 32'hFFFF_FFFF, 2'd3);
    check("R6 none value", addr_out, 32'h40);
    request("R4 all terms", 1'b1, 32'h0010_0000, 32'h0000_3000, 32'h0000_0007, 2'd2,
            32'h0000_0010, 2'd0);
  endtask

  task automatic t_wrap;
    request("R7 scaled wrap", 1'b1, 32'hFFFF_FFF0, 32'h20, 32'h8000_0000, 2'd1,
            32'h0, 2'd3);
    check("R7 scaled value", addr_out, 32'h0000_0010);
  endtask

  task automatic t_hold;
    logic [31:0] held;
    request("R8 seed", 1'b1, 32'h5000, 32'h6, 32'h0, 2'd0, 32'h0, 2'd3);
    held = addr_out;
    @(negedge clk);
    in_valid = 1'b0; mode = 1'b1; seg_in = 32'hDEAD_BEEF; base_in = 32'h1;
    @(posedge clk); #1;
    check("R8 valid drop", {31'h0, out_valid}, 32'h0);
    @(posedge clk); #1;
    check("R9 addr held", addr_out, held);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0; seg_in = 0; base_in = 0;
    index_in = 0; scale_code = 0; disp_in = 0; disp_size = 0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R1 after release", {31'h0, out_valid}, 32'h0);
    t_para();
    t_scale();
    t_disp();
    t_wrap();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule